// File: doc/BRIEF.md
# Serial Shift-Add Multiply Accumulator

This block forms one output of an interpolation filter. It takes seven taps, one after another. Each tap is a 12-bit two's-complement sample paired with an 8-bit two's-complement coefficient. The block multiplies each pair by walking the coefficient one bit per clock, from the least significant bit upward. On every step a shifted, sign-extended copy of the sample is conditionally added into a 20-bit accumulator. On the last step, which is the coefficient sign bit, the copy is subtracted instead. The same adder performs both the multiply steps and the running sum, so the block has no separate product adder.

The coefficients are fixed point with 7 fractional bits. After the seventh product has been added, the accumulator is arithmetically shifted right by 7 and clamped into 12 bits. The result is then presented together with a one-cycle done pulse. Sample and coefficient storage sit outside the block: the surrounding logic offers one pair per tap with a valid signal and waits for the ready signal. A clear pulse starts a new output from zero. Without a clear, the next seven taps add on top of the previous sum.

Top module: `shift_add_mac`

## Requirements
- R1: After synchronous reset, `tap_ready_o` is 1, `done_o` is 0 and `result_o` is 0.
- R2: A tap is taken on a clock edge where `tap_valid_i` and `tap_ready_o` are both 1 and `clear_i` is 0. `tap_ready_o` is then 0 for exactly 8 cycles, one per coefficient bit.
- R3: Each product is the signed product of the sample and the coefficient. Coefficient bit 7 carries weight -128, so coefficient 8'h80 means -128 and 8'h7F means +127.
- R4: The seven products are summed in a 20-bit two's-complement accumulator that wraps modulo 2^20.
- R5: `result_o` equals the accumulator shifted arithmetically right by 7 and clamped to the range -2048..2047. It changes only in the cycle where `done_o` is 1 and holds its value otherwise.
- R6: `done_o` is 1 for exactly one cycle. That cycle comes two clock edges after the edge that applies the last bit step of the seventh tap.
- R7: `clear_i` zeroes the accumulator and the tap count, and aborts any tap in progress. It takes priority over `tap_valid_i` in the same cycle. `tap_ready_o` is 1 in the cycle after the clear.
- R8: When no clear is given between outputs, the next seven taps accumulate onto the previous 20-bit sum.
- R9: Sample and coefficient values offered while `tap_ready_o` is 0 are ignored.
- R10: With taps offered back to back, `done_o` rises no later than 128 cycles after the first tap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Zero the accumulator and restart the tap count |
| tap_valid_i | input | 1 | A sample/coefficient pair is offered |
| sample_i | input | 12 | Two's-complement sample |
| coef_i | input | 8 | Two's-complement coefficient, 7 fractional bits |
| tap_ready_o | output | 1 | Block can take a tap this cycle |
| result_o | output | 12 | Scaled and clamped sum |
| done_o | output | 1 | One-cycle pulse when `result_o` is new |

## Verification
A corrupt accumulator, shift register or operand latch stays hidden until the done pulse. It then appears as a wrong `result_o` at most about 64 cycles after the first tap of that group, or in a later group when no clear intervenes. A wrong bit counter or tap counter shows sooner: `tap_ready_o` stays low for the wrong number of cycles, or `done_o` fires early or late. The bench's cycle model therefore compares the ready, done and result outputs on every clock. Directed groups cover the -128 coefficient, saturation at both ends, accumulator wrap, carry-over without a clear, aborted taps and data offered while busy.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_EMIT = 2'd2
  } mac_state_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int TAPS   = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic tap_valid_i,
  output logic ready_o,
  output logic load_o,
  output logic step_o,
  output logic last_bit_o,
  output logic emit_o
);
  localparam int BIT_W = (COEF_W > 1) ? $clog2(COEF_W) : 1;
  localparam int TAP_W = $clog2(TAPS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(COEF_W - 1);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);

  mac_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [TAP_W-1:0] tap_q;

  always_comb begin
    ready_o    = (state_q == ST_IDLE);
    load_o     = ready_o && tap_valid_i && !clear_i;
    step_o     = (state_q == ST_BUSY) && !clear_i;
    last_bit_o = (bit_q == LAST_BIT);
    emit_o     = (state_q == ST_EMIT) && !clear_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      tap_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (tap_valid_i) begin
          state_q <= ST_BUSY;
          bit_q   <= '0;
        end
        ST_BUSY: if (last_bit_o) begin
          bit_q <= '0;
          if (tap_q == LAST_TAP) begin
            tap_q   <= '0;
            state_q <= ST_EMIT;
          end else begin
            tap_q   <= tap_q + 1'b1;
            state_q <= ST_IDLE;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !ready_o);
  // R7
  clear_idles_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (ready_o && !emit_o));
  // R10
  tap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tap_q <= LAST_TAP);
  // R6
  emit_single_chk: assert property (@(posedge clk) disable iff (rst)
    emit_o |=> !emit_o);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear_i,
  input  logic                    load_i,
  input  logic                    step_i,
  input  logic                    last_bit_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [COEF_W-1:0]       coef_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic [ACC_W-1:0]  mcand_q;
  logic [COEF_W-1:0] mult_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  addend;
  logic [ACC_W-1:0]  sum;
  logic              sub;

  // single shared adder: partial product terms and the running sum
  always_comb begin
    sub    = last_bit_i && mult_q[0];
    addend = mult_q[0] ? mcand_q : '0;
    sum    = acc_q + (sub ? ~addend : addend) + ACC_W'(sub);
    acc_o  = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mult_q  <= '0;
    end else if (load_i) begin
      mcand_q <= {{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i};
      mult_q  <= coef_i;
    end else if (step_i) begin
      acc_q   <= sum;
      mcand_q <= mcand_q << 1;
      mult_q  <= mult_q >> 1;
    end
  end

  // R9
  operands_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i && !clear_i) |=> ($stable(mult_q) && $stable(mcand_q)));
  // R7
  acc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (acc_q == '0));
  // R4
  acc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !clear_i) |=> $stable(acc_q));
endmodule

// File: rtl/mac_outstage.sv
module mac_outstage #(
  parameter int ACC_W  = 20,
  parameter int FRAC_W = 7,
  parameter int OUT_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    emit_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0]        result_o,
  output logic                    done_o
);
  localparam int SH_W = ACC_W - FRAC_W;

  logic signed [SH_W-1:0] shifted;
  logic [OUT_W-1:0]       sat_val;

  assign shifted = acc_i[ACC_W-1:FRAC_W];

  generate
    if (SH_W > OUT_W) begin : g_clamp
      localparam logic signed [SH_W-1:0] HI = SH_W'((64'sd1 <<< (OUT_W - 1)) - 1);
      localparam logic signed [SH_W-1:0] LO = ~HI;
      always_comb begin
        if (shifted > HI)      sat_val = HI[OUT_W-1:0];
        else if (shifted < LO) sat_val = LO[OUT_W-1:0];
        else                   sat_val = shifted[OUT_W-1:0];
      end
    end else begin : g_extend
      always_comb sat_val = OUT_W'(shifted);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= emit_i;
      if (emit_i) result_o <= sat_val;
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5
  result_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> done_o);
endmodule

// File: rtl/shift_add_mac.sv
module shift_add_mac #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 8,
  parameter int TAPS     = 7,
  parameter int FRAC_W   = 7,
  parameter int ACC_W    = 20,
  parameter int OUT_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic                tap_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [COEF_W-1:0]   coef_i,
  output logic                tap_ready_o,
  output logic [OUT_W-1:0]    result_o,
  output logic                done_o
);
  logic load, step, last_bit, emit;
  logic signed [ACC_W-1:0] acc;

  mac_ctrl #(.COEF_W(COEF_W), .TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .clear_i(clear_i), .tap_valid_i(tap_valid_i),
    .ready_o(tap_ready_o), .load_o(load), .step_o(step),
    .last_bit_o(last_bit), .emit_o(emit)
  );

  mac_datapath #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst(rst), .clear_i(clear_i), .load_i(load), .step_i(step),
    .last_bit_i(last_bit), .sample_i(sample_i), .coef_i(coef_i), .acc_o(acc)
  );

  mac_outstage #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .emit_i(emit), .acc_i(acc),
    .result_o(result_o), .done_o(done_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (tap_ready_o && !done_o && result_o == '0));
endmodule

// File: tb/test_shift_add_mac.sv
module test_shift_add_mac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear_i = 1'b0;
  logic        tap_valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic [7:0]  coef_i = '0;
  logic        tap_ready_o;
  logic [11:0] result_o;
  logic        done_o;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  shift_add_mac i_shift_add_mac (
    .clk(clk), .rst(rst), .clear_i(clear_i), .tap_valid_i(tap_valid_i),
    .sample_i(sample_i), .coef_i(coef_i), .tap_ready_o(tap_ready_o),
    .result_o(result_o), .done_o(done_o)
  );

  function automatic int ref_out(input logic signed [19:0] a);
    int v;
    v = int'(a) >>> 7;
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural cycle model
  logic               m_ready = 1'b1;
  logic               m_done = 1'b0;
  int                 m_result = 0;
  int                 m_steps = 0;
  int                 m_taps = 0;
  logic signed [19:0] m_acc = '0;
  logic               m_emit = 1'b0;

  always @(posedge clk) begin
    cyc++;
    m_done = 1'b0;
    if (rst) begin
      m_ready = 1; m_result = 0; m_steps = 0; m_taps = 0; m_acc = '0; m_emit = 0;
    end else if (clear_i) begin
      m_ready = 1; m_steps = 0; m_taps = 0; m_acc = '0; m_emit = 0;
    end else if (m_emit) begin
      m_result = ref_out(m_acc); m_done = 1; m_emit = 0; m_ready = 1;
    end else if (m_steps > 0) begin
      m_steps--;
      if (m_steps == 0) begin
        m_taps++;
        if (m_taps == 7) begin m_taps = 0; m_emit = 1; m_ready = 0; end
        else m_ready = 1;
      end
    end else if (tap_valid_i) begin
      m_acc = m_acc + 20'(int'($signed(sample_i)) * int'($signed(coef_i)));
      m_steps = 8; m_ready = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 ready", int'(tap_ready_o), int'(m_ready));
      check("R6 done", int'(done_o), int'(m_done));
      check("R5 result", int'($signed(result_o)), m_result);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  int exp_acc = 0;

  function automatic int wrap20(input int v);
    logic signed [19:0] w;
    w = 20'(v);
    return int'(w);
  endfunction

  task automatic send_tap(input int s, input int c);
    sample_i = 12'(s); coef_i = 8'(c); tap_valid_i = 1'b1;
    while (!tap_ready_o) @(negedge clk);
    @(negedge clk);
    exp_acc = wrap20(exp_acc + s * c);
  endtask

  task automatic pulse_clear();
    clear_i = 1'b1; tap_valid_i = 1'b0;
    @(negedge clk);
    clear_i = 1'b0;
    exp_acc = 0;
  endtask

  task automatic finish_group(input string tag, input int t0);
    int guard;
    tap_valid_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 300) begin @(negedge clk); guard++; end
    check({tag, " value"}, int'($signed(result_o)), ref_out(20'(exp_acc)));
    check("R10 latency within 128", int'((cyc - t0) <= 128), 1);
  endtask

  task automatic run_group(input string tag, input int s[7], input int c[7], input bit clr);
    int t0;
    if (clr) pulse_clear();
    t0 = 0;
    for (int k = 0; k < 7; k++) begin
      send_tap(s[k], c[k]);
      if (k == 0) t0 = cyc;
    end
    finish_group(tag, t0);
  endtask

  initial begin
    int sa[7];
    int ca[7];
    int t0;
    int seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ready", int'(tap_ready_o), 1);
    check("R1 done", int'(done_o), 0);
    check("R1 result", int'(result_o), 0);

    // R4 mixed signs
    sa = '{100, -200, 300, -400, 512, -7, 1};
    ca = '{10, -20, 30, 127, -128, 5, 64};
    run_group("R4 mixed", sa, ca, 1);

    // R3 coefficient -128 on a single tap
    sa = '{100, 0, 0, 0, 0, 0, 0};
    ca = '{-128, 0, 0, 0, 0, 0, 0};
    run_group("R3 neg128", sa, ca, 1);
    check("R3 direct -100", int'($signed(result_o)), -100);

    // R5 positive clamp: -2048 * -128 -> 2048 after scaling
    sa = '{-2048, 0, 0, 0, 0, 0, 0};
    ca = '{-128, 0, 0, 0, 0, 0, 0};
    run_group("R5 clamp hi", sa, ca, 1);
    check("R5 direct 2047", int'($signed(result_o)), 2047);

    // R5 negative clamp
    sa = '{-2048, -2048, 0, 0, 0, 0, 0};
    ca = '{127, 127, 0, 0, 0, 0, 0};
    run_group("R5 clamp lo", sa, ca, 1);
    check("R5 direct -2048", int'($signed(result_o)), -2048);

    // R4 accumulator wrap
    sa = '{2047, 2047, 2047, 2047, 2047, 2047, 2047};
    ca = '{127, 127, 127, 127, 127, 127, 127};
    run_group("R4 wrap", sa, ca, 1);

    // R8 no clear: adds onto previous sum
    sa = '{-50, 60, -70, 80, -90, 100, -110};
    ca = '{3, 3, 3, 3, 3, 3, 3};
    pulse_clear();
    run_group("R8 first", sa, ca, 0);
    run_group("R8 carried", sa, ca, 0);

    // R7 abort tap in progress
    pulse_clear();
    send_tap(1000, 100);
    tap_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    pulse_clear();
    check("R7 ready after clear", int'(tap_ready_o), 1);
    // R7 clear wins over valid
    clear_i = 1'b1; tap_valid_i = 1'b1; sample_i = 12'd500; coef_i = 8'd50;
    @(negedge clk);
    clear_i = 1'b0; tap_valid_i = 1'b0;
    check("R7 clear priority ready", int'(tap_ready_o), 1);
    sa = '{1, 2, 3, 4, 5, 6, 7};
    ca = '{64, 64, 64, 64, 64, 64, 64};
    run_group("R7 after abort", sa, ca, 0);

    // R9 data offered while busy is ignored
    pulse_clear();
    send_tap(256, 64);
    t0 = cyc;
    sample_i = 12'h7FF; coef_i = 8'h7F; tap_valid_i = 1'b1;
    @(negedge clk);
    check("R9 busy ignores", int'(tap_ready_o), 0);
    @(negedge clk);
    tap_valid_i = 1'b0;
    for (int k = 0; k < 6; k++) send_tap(-30 * k, 20);
    finish_group("R9", t0);

    // varied groups with gaps between taps
    seed = 7;
    for (int g = 0; g < 6; g++) begin
      if (g % 2 == 0) pulse_clear();
      for (int k = 0; k < 7; k++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
        send_tap(((seed >> 4) % 4096) - 2048, ((seed >> 16) % 256) - 128);
        if (k == 0) t0 = cyc;
        tap_valid_i = 1'b0;
        repeat (seed % 3) @(negedge clk);
      end
      finish_group("R4 varied", t0);
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule